// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock synthesizer and the clock output pins. It gates two clock families, the CPU clock and the PCI clock, in response to two active-low stop requests. An active-low power-down request gates everything: the CPU clock, the PCI clock, the free-running PCI clock and the reference clock. All three requests arrive asynchronously. Both stop requests are resampled on the rising edge of the free-running PCI clock. The power-down request is resampled in the reference clock domain. No gate ever produces a shortened high pulse. A stopped clock rests low, and a restarted clock begins with a complete high phase.

Power-down also drops two flags that tell the synthesizer it may turn off its crystal oscillator and its VCO. When power-down is released, the oscillator flag returns first and the VCO flag follows one reference cycle later. A power-up counter clocked by the reference clock must then expire before any clock is released. The same sequence runs after reset. The counter length is a parameter. Its default covers roughly 3 ms of a 14.318 MHz reference, and a simulation can set it much shorter.

The internal PCI clock and the free-running PCI clock input must have the same frequency and phase. The internal CPU clock must run at a whole multiple of the PCI clock, with its rising edges aligned to the PCI clock's rising edges.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_ni` is low and the block is running, `cpu_clk_o` stays low. `pci_clk_o`, `pci_free_clk_o` and `ref_clk_o` keep toggling.
- R2: While `pci_stop_ni` is low and the block is running, `pci_clk_o` stays low. `pci_free_clk_o` and `cpu_clk_o` keep toggling.
- R3: Every gated output is low whenever its source clock is low. Each high pulse on `cpu_clk_o` or `pci_clk_o` spans the full high phase of its source clock.
- R4: `cpu_stop_ni` passes through two flops clocked on the free-running PCI rising edge. Call E1 the edge at which the second flop takes a new value. The first `cpu_clk_o` high phase that reflects the new value starts two CPU periods after E1.
- R5: `pci_stop_ni` passes through the same two-flop path as in R4. The first `pci_clk_o` high phase that reflects the new value starts exactly one free-running PCI rising edge after E1.
- R6: Asserting `pwr_dn_ni` low forces `ref_clk_o` low at once, without waiting for a clock edge. Within 600 ns, `cpu_clk_o`, `pci_clk_o` and `pci_free_clk_o` are also held low. While power-down lasts, both stop requests have no effect on any output. While the block is running, `ref_clk_o` follows `ref_clk_i`.
- R7: Within three reference edges of power-down, `osc_en_o` and `vco_en_o` go low. On release, `osc_en_o` rises first and `vco_en_o` rises one reference cycle later.
- R8: After reset release or power-down release, no gated output has a rising edge for `PWRUP_CYCLES` reference periods. All clocks then resume within a bounded number of further cycles.
- R9: During reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Internal CPU clock |
| pci_clk_i | input | 1 | Internal PCI clock to be gated |
| pci_free_clk_i | input | 1 | Free-running PCI clock; also clocks the stop synchronizers |
| ref_clk_i | input | 1 | Reference clock; also clocks the power-up logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_stop_ni | input | 1 | Asynchronous CPU clock stop request, active low |
| pci_stop_ni | input | 1 | Asynchronous PCI clock stop request, active low |
| pwr_dn_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_o | output | 1 | Gated CPU clock |
| pci_clk_o | output | 1 | Gated PCI clock |
| pci_free_clk_o | output | 1 | Free-running PCI clock, stopped only in power-down |
| ref_clk_o | output | 1 | Reference clock output, stopped only in power-down |
| osc_en_o | output | 1 | Oscillator enable flag |
| vco_en_o | output | 1 | VCO enable flag |

## Verification
The assertions check several properties on every cycle:
- Each gate's enable register holds the value its request had at the source clock's previous rising edge, which is what keeps every pulse full width.
- The power-up sequencer reaches the run state only from the final count value.
- Power-down takes the run state and both flags down on the next reference edge.
- The reference gate is held cleared for as long as power-down is low.

Some behaviours only the bench scenarios can show:
- The exact CPU and PCI on and off latencies, measured against the free-running PCI edges.
- The fact that stop requests toggled during power-down leave the outputs untouched.
- The silent window after release.
- The oscillator-before-VCO order.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAIT = 2'd1,
    PS_RUN  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {N{RST_VAL}};
    else         sync_q <= {sync_q[N-2:0], d_i};
  end

  assign q_o = sync_q[N-1];
endmodule

// File: rtl/clk_gate.sv
`timescale 1ns/1ps
module clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable only moves while the source clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;

  // R3: the enable seen during a high phase is the request from that phase's rising edge
  a_r3_gate_en_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == en_i);
endmodule

// File: rtl/pwrup_ctrl.sv
`timescale 1ns/1ps
module pwrup_ctrl
  import clk_stop_pkg::*;
#(
  parameter int PWRUP_CYCLES = 42954,
  parameter int SYNC_STAGES  = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic run_o,
  output logic osc_en_o,
  output logic vco_en_o
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

  logic              pd_n_sync;
  pwr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              osc_q, vco_q;

  cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_ni),
    .q_o   (pd_n_sync)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_OFF: begin
        cnt_d = '0;
        if (pd_n_sync) state_d = PS_WAIT;
      end
      PS_WAIT: begin
        if (!pd_n_sync)       state_d = PS_OFF;
        else if (cnt_q == LAST) state_d = PS_RUN;
        else                  cnt_d = cnt_q + 1'b1;
      end
      PS_RUN: begin
        if (!pd_n_sync) state_d = PS_OFF;
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
      osc_q   <= 1'b0;
      vco_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      osc_q   <= pd_n_sync;
      vco_q   <= pd_n_sync & osc_q;
    end
  end

  assign run_o    = (state_q == PS_RUN);
  assign osc_en_o = osc_q;
  assign vco_en_o = vco_q;

  // R8: run only after the full count
  a_r8_run_after_count: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(cnt_q) == LAST);
  // R8: power-down aborts run at the next edge
  a_r8_pd_drops_run: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !pd_n_sync |=> !run_o);
  // R7: flags fall with the synchronized request
  a_r7_flags_off: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !pd_n_sync |=> (!osc_en_o && !vco_en_o));
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int PWRUP_CYCLES = 42954,
  parameter int SYNC_STAGES  = 2
) (
  input  logic cpu_clk_i,
  input  logic pci_clk_i,
  input  logic pci_free_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic cpu_stop_ni,
  input  logic pci_stop_ni,
  input  logic pwr_dn_ni,
  output logic cpu_clk_o,
  output logic pci_clk_o,
  output logic pci_free_clk_o,
  output logic ref_clk_o,
  output logic osc_en_o,
  output logic vco_en_o
);
  localparam int NUM_REQ = 3;

  logic              run_ref;
  logic [NUM_REQ-1:0] req_raw, req_pf;
  logic              cpu_run_pf, pci_run_pf, run_pf;
  logic              cpu_en_q;
  logic              ref_arst_n, ref_en_q;

  pwrup_ctrl #(.PWRUP_CYCLES(PWRUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_pwrup (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pwr_dn_ni),
    .run_o    (run_ref),
    .osc_en_o (osc_en_o),
    .vco_en_o (vco_en_o)
  );

  // run and both stop requests resampled on the free-running PCI clock
  assign req_raw = {run_ref, pci_stop_ni, cpu_stop_ni};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req_sync
    cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == NUM_REQ - 1 ? 1'b0 : 1'b1)) u_sync (
      .clk_i (pci_free_clk_i),
      .rst_ni(rst_ni),
      .d_i   (req_raw[g]),
      .q_o   (req_pf[g])
    );
  end

  assign run_pf     = req_pf[2];
  assign cpu_run_pf = run_pf & req_pf[0];
  assign pci_run_pf = run_pf & req_pf[1];

  // CPU edges are aligned with the PCI edges, so one retiming flop suffices
  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_en_q <= 1'b0;
    else         cpu_en_q <= cpu_run_pf;
  end

  clk_gate u_gate_cpu (
    .clk_i (cpu_clk_i),
    .rst_ni(rst_ni),
    .en_i  (cpu_en_q),
    .clk_o (cpu_clk_o)
  );

  clk_gate u_gate_pci (
    .clk_i (pci_clk_i),
    .rst_ni(rst_ni),
    .en_i  (pci_run_pf),
    .clk_o (pci_clk_o)
  );

  clk_gate u_gate_pci_free (
    .clk_i (pci_free_clk_i),
    .rst_ni(rst_ni),
    .en_i  (run_pf),
    .clk_o (pci_free_clk_o)
  );

  // reference output is cleared directly by power-down
  assign ref_arst_n = rst_ni & pwr_dn_ni;

  always_ff @(negedge ref_clk_i or negedge ref_arst_n) begin
    if (!ref_arst_n) ref_en_q <= 1'b0;
    else             ref_en_q <= run_ref;
  end

  assign ref_clk_o = ref_clk_i & ref_en_q;

  // R6: reference gate stays cleared for as long as power-down is held
  a_r6_ref_held_in_pd: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> !ref_en_q);
endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;
  localparam int  PWRUP = 8;
  localparam real REF_T = 70.0;

  logic cpu_clk, pci_clk, ref_clk, rst_ni;
  logic cpu_stop_ni, pci_stop_ni, pwr_dn_ni;
  logic cpu_clk_o, pci_clk_o, pci_free_clk_o, ref_clk_o, osc_en_o, vco_en_o;

  int  n_chk = 0;
  int  n_err = 0;
  int  run_known = 0;   // 0 unknown, 1 running, 2 powered down
  bit  quiet_win = 1'b1;
  int  qedges = 0;

  bit  cpu_prev = 1'b1, cpu_next = 1'b1;
  bit  pci_prev = 1'b1, pci_next = 1'b1;
  real cpu_te = 0.0, pci_te = 0.0;

  clk_stop_ctrl #(.PWRUP_CYCLES(PWRUP), .SYNC_STAGES(2)) u_dut (
    .cpu_clk_i     (cpu_clk),
    .pci_clk_i     (pci_clk),
    .pci_free_clk_i(pci_clk),
    .ref_clk_i     (ref_clk),
    .rst_ni        (rst_ni),
    .cpu_stop_ni   (cpu_stop_ni),
    .pci_stop_ni   (pci_stop_ni),
    .pwr_dn_ni     (pwr_dn_ni),
    .cpu_clk_o     (cpu_clk_o),
    .pci_clk_o     (pci_clk_o),
    .pci_free_clk_o(pci_free_clk_o),
    .ref_clk_o     (ref_clk_o),
    .osc_en_o      (osc_en_o),
    .vco_en_o      (vco_en_o)
  );

  // 100 MHz CPU clock, PCI at a third of it with aligned rising edges
  initial begin cpu_clk = 1'b0; forever #5 cpu_clk = ~cpu_clk; end
  initial begin
    pci_clk = 1'b0; #5;
    forever begin pci_clk = 1'b1; #15; pci_clk = 1'b0; #15; end
  end
  initial begin ref_clk = 1'b0; forever #35 ref_clk = ~ref_clk; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic real next_pci_rise(input real t);
    return 5.0 + 30.0 * ($floor((t - 5.0) / 30.0) + 1.0);
  endfunction

  // inputs change one ns after a PCI falling edge
  task automatic set_cpu_stop(input bit v);
    @(negedge pci_clk); #1;
    cpu_stop_ni = v;
    cpu_prev = cpu_next; cpu_next = v;
    cpu_te = next_pci_rise($realtime) + 30.0 + 20.0;  // E1 + 2 CPU periods
  endtask

  task automatic set_pci_stop(input bit v);
    @(negedge pci_clk); #1;
    pci_stop_ni = v;
    pci_prev = pci_next; pci_next = v;
    pci_te = next_pci_rise($realtime) + 30.0 + 30.0;  // E1 + one PCI edge
  endtask

  always @(posedge cpu_clk_o or posedge pci_clk_o or posedge pci_free_clk_o or posedge ref_clk_o)
    if (quiet_win) qedges++;

  // CPU output compared on every CPU cycle
  always @(posedge cpu_clk) begin
    realtime p;
    logic a;
    bit e;
    p = $realtime;
    #2;
    a = cpu_clk_o;
    e = (p >= cpu_te) ? cpu_next : cpu_prev;
    if (run_known == 1)      check(a == e,    "R1 R4 cpu_clk_o", int'(a), int'(e));
    else if (run_known == 2) check(a == 1'b0, "R6 cpu_clk_o", int'(a), 0);
    #2 check(cpu_clk_o == a, "R3 cpu full pulse", int'(cpu_clk_o), int'(a));
    #3 check(cpu_clk_o == 1'b0, "R3 cpu parks low", int'(cpu_clk_o), 0);
  end

  // PCI outputs compared on every PCI cycle
  always @(posedge pci_clk) begin
    realtime p;
    logic a;
    bit e;
    p = $realtime;
    #2;
    a = pci_clk_o;
    e = (p >= pci_te) ? pci_next : pci_prev;
    if (run_known == 1) begin
      check(a == e, "R2 R5 pci_clk_o", int'(a), int'(e));
      check(pci_free_clk_o == 1'b1, "R2 pci_free_clk_o", int'(pci_free_clk_o), 1);
    end else if (run_known == 2) begin
      check(a == 1'b0, "R6 pci_clk_o", int'(a), 0);
      check(pci_free_clk_o == 1'b0, "R6 pci_free_clk_o", int'(pci_free_clk_o), 0);
    end
    #11 check(pci_clk_o == a, "R3 pci full pulse", int'(pci_clk_o), int'(a));
    #4  check(pci_clk_o == 1'b0 && pci_free_clk_o == 1'b0, "R3 pci parks low",
              int'(pci_clk_o | pci_free_clk_o), 0);
  end

  always @(posedge ref_clk) begin
    #2;
    if (run_known == 1)      check(ref_clk_o == 1'b1, "R1 R6 ref_clk_o runs", int'(ref_clk_o), 1);
    else if (run_known == 2) check(ref_clk_o == 1'b0, "R6 ref_clk_o off", int'(ref_clk_o), 0);
  end

  task automatic await_run(input real tr);
    wait (osc_en_o == 1'b1);
    #1 check(vco_en_o == 1'b0, "R7 vco after osc", int'(vco_en_o), 0);
    @(posedge ref_clk); #1;
    check(vco_en_o == 1'b1, "R7 vco one cycle later", int'(vco_en_o), 1);
    if ($realtime < tr + PWRUP * REF_T) #(tr + PWRUP * REF_T - $realtime);
    quiet_win = 1'b0;
    check(qedges == 0, "R8 silent window", qedges, 0);
    #700;
    run_known = 1;
    check(osc_en_o && vco_en_o, "R7 flags on", int'(osc_en_o & vco_en_o), 1);
  endtask

  initial begin
    #100000;
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cpu_stop_ni = 1'b1; pci_stop_ni = 1'b1; pwr_dn_ni = 1'b1;
    #50;
    check({cpu_clk_o, pci_clk_o, pci_free_clk_o, ref_clk_o, osc_en_o, vco_en_o} == 6'b0,
          "R9 reset state",
          int'({cpu_clk_o, pci_clk_o, pci_free_clk_o, ref_clk_o, osc_en_o, vco_en_o}), 0);
    #50 rst_ni = 1'b1;
    await_run(100.0);
    #300;

    // single stops, R1 R4 / R2 R5
    set_cpu_stop(1'b0); #400;
    set_cpu_stop(1'b1); #400;
    set_pci_stop(1'b0); #400;
    set_pci_stop(1'b1); #400;

    // overlapping stops
    set_cpu_stop(1'b0); #100;
    set_pci_stop(1'b0); #300;
    set_cpu_stop(1'b1); #200;
    set_pci_stop(1'b1); #400;

    // power-down asserted while the reference clock is high
    @(posedge ref_clk); #10;
    pwr_dn_ni = 1'b0;
    run_known = 0;
    #1 check(ref_clk_o == 1'b0, "R6 ref stops at once", int'(ref_clk_o), 0);
    #600;
    run_known = 2;
    check(!osc_en_o && !vco_en_o, "R7 flags off", int'(osc_en_o | vco_en_o), 0);

    // stops toggled during power-down have no effect
    set_cpu_stop(1'b0); #150;
    set_pci_stop(1'b0); #300;
    set_cpu_stop(1'b1); #150;
    set_pci_stop(1'b1); #400;

    begin
      real tr;
      @(negedge pci_clk); #1;
      pwr_dn_ni = 1'b1;
      tr = $realtime;
      run_known = 0;
      qedges = 0;
      quiet_win = 1'b1;
      await_run(tr);
    end
    #300;
    set_cpu_stop(1'b0); #300;
    set_cpu_stop(1'b1); #400;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule